// File: doc/BRIEF.md
# Thermostat Alert with Fault Queue

This block watches a stream of 12-bit signed temperature results and drives a single alert line. Each new result, marked by a one-cycle valid pulse, is compared with a programmable upper limit and a programmable lower limit. The alert only changes after a programmable number of consecutive qualifying results, so that a single noisy reading cannot flip it.

Two behaviours are selectable. In comparator mode the alert acts as a thermostat with hysteresis: it turns on once the temperature sits at or above the upper limit and turns off once it sits below the lower limit. In interrupt mode the alert is latched when raised and stays raised until software or the bus logic clears it with a register read, a won alert-response arbitration or entry into shutdown; after each clear the watched limit swaps, so events alternate between "got hot" and "got cold". A status bit tells the alert-response logic which limit raised the most recent alert, and a polarity input picks an active-low or active-high pin. A general-call reset input returns the alert logic to its idle state. Limits and configuration are held by the surrounding register file.

Top module: `thermo_alert`

## Requirements
- R1: `queue_sel` sets the count of consecutive valid qualifying samples needed for the alert to change: 2'b00 needs 1, 2'b01 needs 2, 2'b10 needs 4, 2'b11 needs 6.
- R2: In comparator mode (`intr_mode`=0) with the alert inactive, the alert becomes active on the clock edge that takes the N-th consecutive valid sample that is at or above `hi_limit`; the compare is signed two's complement over all 12 bits.
- R3: In comparator mode with the alert active, the alert becomes inactive on the edge that takes the N-th consecutive valid sample strictly below `lo_limit` (signed); samples between the limits hold it.
- R4: In interrupt mode (`intr_mode`=1) the alert becomes active after N consecutive valid samples meeting the watched limit, ignores further samples while active, and is cleared on the edge where `reg_read`, `ar_won` or `shutdown` is high.
- R5: In interrupt mode the watched limit starts as the upper limit (sample >= `hi_limit`) and swaps on every clear: after a clear only N samples below `lo_limit` raise it, after the next clear only samples at or above `hi_limit` do.
- R6: A valid sample that does not meet the watched condition restarts the consecutive count; cycles with `sample_valid`=0 neither count nor restart it.
- R7: `alert_pin` is the active alert level when `pol`=1 and its inverse when `pol`=0 (active low); it follows `pol` without a clock.
- R8: `alert_src` is 1 when the most recent alert was raised by the upper limit and 0 when raised by the lower limit; it is 0 after reset.
- R9: `gc_reset` high on an edge clears the alert, the count, the watched limit and `alert_src`; a change of `intr_mode` clears the alert, the count and the watched limit.
- R10: In comparator mode `reg_read`, `ar_won` and `shutdown` have no effect on the alert.
- R11: After `rst_n` is released the alert is inactive and `alert_src` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | One-cycle pulse marking a new result |
| sample | input | 12 | Signed temperature result, 1/16 degree per LSB |
| hi_limit | input | 12 | Signed upper limit |
| lo_limit | input | 12 | Signed lower limit |
| queue_sel | input | 2 | Consecutive-sample count select |
| intr_mode | input | 1 | 0 comparator mode, 1 interrupt mode |
| pol | input | 1 | 0 active-low pin, 1 active-high pin |
| reg_read | input | 1 | Pulse: a register was read (interrupt clear) |
| ar_won | input | 1 | Pulse: alert-response arbitration won (interrupt clear) |
| shutdown | input | 1 | Shutdown request (interrupt clear) |
| gc_reset | input | 1 | General-call reset of the alert logic |
| alert_pin | output | 1 | Alert pin level |
| alert_src | output | 1 | 1 upper limit, 0 lower limit caused the alert |

## Verification
The bench drives runs that stop one sample short of the queue depth for every `queue_sel` value, so a depth decode off by one would raise the alert early or late. It breaks a run with a single non-qualifying sample and with idle cycles, which catches a counter that does not restart or that counts cycles rather than samples. It uses negative limits and a one-LSB difference in the upper limit, which an unsigned or truncated compare would get wrong, and walks the interrupt cycle through all three clear sources, where a design that forgot to swap the watched limit would re-raise on the wrong threshold or report the wrong `alert_src`. It also pulses the clears in comparator mode, where a design that obeyed them would drop the alert.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    // Registered control state of the alert engine.
    typedef struct packed {
        logic alert;      // logical alert, 1 = active
        logic watch_low;  // 1 = watching for samples below the low limit
        logic src;        // limit that raised the latest alert (1 = high)
        logic mode;       // intr_mode seen on the previous edge
    } tsa_ctl_t;

    localparam tsa_ctl_t TSA_CTL_RESET = '{alert: 1'b0, watch_low: 1'b0, src: 1'b0, mode: 1'b0};

endpackage

// File: rtl/tsa_limit_cmp.sv
module tsa_limit_cmp #(
    parameter int TEMP_W = 12
) (
    input  logic [TEMP_W-1:0] sample,
    input  logic [TEMP_W-1:0] hi_limit,
    input  logic [TEMP_W-1:0] lo_limit,
    output logic              at_or_above_hi,
    output logic              below_lo
);

    // Signed compare over every bit, regardless of converter resolution.
    always_comb begin
        at_or_above_hi = $signed(sample) >= $signed(hi_limit);
        below_lo       = $signed(sample) <  $signed(lo_limit);
    end

endmodule

// File: rtl/tsa_fault_run.sv
module tsa_fault_run #(
    parameter int NEED0 = 1,
    parameter int NEED1 = 2,
    parameter int NEED2 = 4,
    parameter int NEED3 = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       step,
    input  logic       hit,
    input  logic [1:0] queue_sel,
    output logic       reached
);

    localparam int RUN_W = $clog2(NEED3 + 1);

    logic [RUN_W-1:0] run_d, run_q;
    logic [RUN_W:0]   need;
    logic [RUN_W:0]   run_inc;

    always_comb begin
        unique case (queue_sel)
            2'b00:   need = (RUN_W+1)'(NEED0);
            2'b01:   need = (RUN_W+1)'(NEED1);
            2'b10:   need = (RUN_W+1)'(NEED2);
            default: need = (RUN_W+1)'(NEED3);
        endcase
        run_inc = {1'b0, run_q} + 1'b1;
        reached = step && hit && (run_inc >= need);

        run_d = run_q;
        if (flush) begin
            run_d = '0;
        end else if (step) begin
            if (hit && !reached) begin
                run_d = run_inc[RUN_W-1:0];
            end else begin
                run_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    // R1: the run never reaches the deepest queue setting without firing.
    assert_run_below_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < RUN_W'(NEED3));

    // R6: a non-qualifying sample leaves the run at zero.
    assert_miss_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hit) |=> (run_q == '0));

endmodule

// File: rtl/thermo_alert.sv
module thermo_alert #(
    parameter int TEMP_W = 12,
    parameter int NEED0  = 1,
    parameter int NEED1  = 2,
    parameter int NEED2  = 4,
    parameter int NEED3  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [TEMP_W-1:0] sample,
    input  logic [TEMP_W-1:0] hi_limit,
    input  logic [TEMP_W-1:0] lo_limit,
    input  logic [1:0]        queue_sel,
    input  logic              intr_mode,
    input  logic              pol,
    input  logic              reg_read,
    input  logic              ar_won,
    input  logic              shutdown,
    input  logic              gc_reset,
    output logic              alert_pin,
    output logic              alert_src
);

    import tsa_pkg::*;

    tsa_ctl_t ctl_d, ctl_q;

    logic at_hi, below_lo;
    logic mode_chg, clr_req, step, hit, flush, reached;

    tsa_limit_cmp #(.TEMP_W(TEMP_W)) cmp_i (
        .sample         (sample),
        .hi_limit       (hi_limit),
        .lo_limit       (lo_limit),
        .at_or_above_hi (at_hi),
        .below_lo       (below_lo)
    );

    tsa_fault_run #(
        .NEED0 (NEED0),
        .NEED1 (NEED1),
        .NEED2 (NEED2),
        .NEED3 (NEED3)
    ) run_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .step      (step),
        .hit       (hit),
        .queue_sel (queue_sel),
        .reached   (reached)
    );

    always_comb begin
        mode_chg = intr_mode != ctl_q.mode;
        clr_req  = reg_read | ar_won | shutdown;
        flush    = gc_reset | mode_chg;
        // A latched interrupt-mode alert ignores new samples.
        step     = sample_valid && !flush && !(intr_mode && ctl_q.alert);
        hit      = ctl_q.watch_low ? below_lo : at_hi;

        ctl_d      = ctl_q;
        ctl_d.mode = intr_mode;
        if (gc_reset) begin
            ctl_d.alert     = 1'b0;
            ctl_d.watch_low = 1'b0;
            ctl_d.src       = 1'b0;
        end else if (mode_chg) begin
            ctl_d.alert     = 1'b0;
            ctl_d.watch_low = 1'b0;
        end else if (intr_mode) begin
            if (ctl_q.alert && clr_req) begin
                ctl_d.alert     = 1'b0;
                ctl_d.watch_low = !ctl_q.watch_low;
            end else if (reached) begin
                ctl_d.alert = 1'b1;
                ctl_d.src   = !ctl_q.watch_low;
            end
        end else if (reached) begin
            ctl_d.alert     = !ctl_q.alert;
            ctl_d.watch_low = !ctl_q.watch_low;
            if (!ctl_q.alert) begin
                ctl_d.src = 1'b1;
            end
        end

        alert_pin = pol ? ctl_q.alert : !ctl_q.alert;
        alert_src = ctl_q.src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= TSA_CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R2: the alert can only rise on an edge that took a valid sample.
    assert_rise_needs_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.alert) |-> $past(sample_valid));

    // R4: a clear source drops a latched interrupt-mode alert.
    assert_intr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.alert && intr_mode && ctl_q.mode && clr_req && !gc_reset) |=> !ctl_q.alert);

    // R9: general-call reset leaves the alert inactive and the source bit low.
    assert_gc_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gc_reset |=> (!ctl_q.alert && !ctl_q.src));

    // R10: without a sample, comparator mode holds the alert whatever the clears do.
    assert_cmp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!intr_mode && !ctl_q.mode && !gc_reset && !sample_valid) |=> $stable(ctl_q.alert));

endmodule

// File: tb/thermo_alert_tb_top.sv
module thermo_alert_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [11:0] sample = 12'h000;
    logic [11:0] hi_limit = 12'h500;
    logic [11:0] lo_limit = 12'h4B0;
    logic [1:0]  queue_sel = 2'b10;
    logic        intr_mode = 1'b0;
    logic        pol = 1'b0;
    logic        reg_read = 1'b0;
    logic        ar_won = 1'b0;
    logic        shutdown = 1'b0;
    logic        gc_reset = 1'b0;
    logic        alert_pin;
    logic        alert_src;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string phase_tag = "R11";

    always #5 clk = ~clk;

    thermo_alert dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample       (sample),
        .hi_limit     (hi_limit),
        .lo_limit     (lo_limit),
        .queue_sel    (queue_sel),
        .intr_mode    (intr_mode),
        .pol          (pol),
        .reg_read     (reg_read),
        .ar_won       (ar_won),
        .shutdown     (shutdown),
        .gc_reset     (gc_reset),
        .alert_pin    (alert_pin),
        .alert_src    (alert_src)
    );

    // Behavioural reference model, updated on every rising edge.
    bit m_alert = 0, m_low = 0, m_src = 0, m_mode = 0;
    int m_run = 0;

    function automatic int depth(input logic [1:0] q);
        case (q)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 6;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_alert = 0; m_low = 0; m_src = 0; m_mode = 0; m_run = 0;
        end else begin
            int s, h, l;
            bit qual;
            s = $signed(sample); h = $signed(hi_limit); l = $signed(lo_limit);
            qual = m_low ? (s < l) : (s >= h);
            if (gc_reset) begin
                m_alert = 0; m_low = 0; m_src = 0; m_run = 0;
            end else if (intr_mode != m_mode) begin
                m_alert = 0; m_low = 0; m_run = 0;
            end else if (intr_mode && m_alert) begin
                if (reg_read || ar_won || shutdown) begin
                    m_alert = 0; m_low = !m_low;
                end
            end else if (sample_valid) begin
                if (!qual) begin
                    m_run = 0;
                end else begin
                    m_run++;
                    if (m_run >= depth(queue_sel)) begin
                        m_run = 0;
                        if (intr_mode) begin
                            m_alert = 1; m_src = !m_low;
                        end else begin
                            if (!m_alert) m_src = 1;
                            m_alert = !m_alert; m_low = !m_low;
                        end
                    end
                end
            end
            m_mode = intr_mode;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (alert_pin !== (pol ? m_alert : !m_alert) || alert_src !== m_src) begin
                errors++;
                $display("FAIL %s model: pin=%b src=%b expected pin=%b src=%b",
                         phase_tag, alert_pin, alert_src, pol ? m_alert : !m_alert, m_src);
            end
        end
    end

    task automatic expect_state(input bit act, input bit src, input string tag);
        bit exp_pin;
        exp_pin = pol ? act : !act;
        checks++;
        if (alert_pin !== exp_pin) begin
            errors++;
            $display("FAIL %s: alert_pin=%b expected %b", tag, alert_pin, exp_pin);
        end
        checks++;
        if (alert_src !== src) begin
            errors++;
            $display("FAIL %s: alert_src=%b expected %b", tag, alert_src, src);
        end
    endtask

    task automatic feed(input logic [11:0] t, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 sample = t; sample_valid = 1'b1;
            @(posedge clk); #1 sample_valid = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic pulse_read;  @(posedge clk); #1 reg_read = 1;  @(posedge clk); #1 reg_read = 0;  endtask
    task automatic pulse_won;   @(posedge clk); #1 ar_won = 1;    @(posedge clk); #1 ar_won = 0;    endtask
    task automatic pulse_sd;    @(posedge clk); #1 shutdown = 1;  @(posedge clk); #1 shutdown = 0;  endtask
    task automatic pulse_gc;    @(posedge clk); #1 gc_reset = 1;  @(posedge clk); #1 gc_reset = 0;  endtask

    initial begin
        idle(3);
        #1 rst_n = 1'b1;
        idle(2);
        phase_tag = "R11";
        expect_state(0, 0, "R11 reset state");

        // Comparator mode, depth 4.
        phase_tag = "R2";
        feed(12'h500, 3);
        expect_state(0, 0, "R1 three of four samples");
        feed(12'h500, 1);
        expect_state(1, 1, "R2 fourth sample at hi raises");
        expect_state(1, 1, "R8 high-limit source");

        phase_tag = "R10";
        pulse_read; pulse_won; pulse_sd;
        expect_state(1, 1, "R10 clears ignored in comparator mode");

        phase_tag = "R6";
        feed(12'h4AF, 3);
        feed(12'h4C0, 1);
        feed(12'h4AF, 3);
        expect_state(1, 1, "R6 run broken by in-band sample");
        sample = 12'h000;
        idle(4);
        expect_state(1, 1, "R6 idle cycles do not count");
        phase_tag = "R3";
        feed(12'h4AF, 1);
        expect_state(0, 1, "R3 fourth sample below lo clears");

        // Every queue depth.
        phase_tag = "R1";
        for (int q = 0; q < 4; q++) begin
            pulse_gc;
            queue_sel = q[1:0];
            feed(12'h600, depth(q[1:0]) - 1);
            expect_state(0, 0, "R1 one short of depth");
            feed(12'h600, 1);
            expect_state(1, 1, "R1 depth reached");
        end

        // Signed and full-width compares.
        phase_tag = "R2";
        pulse_gc;
        queue_sel = 2'b00;
        hi_limit = 12'hFF0; lo_limit = 12'hFE0;
        feed(12'h800, 1);
        expect_state(0, 0, "R2 most negative below negative hi");
        feed(12'h7F0, 1);
        expect_state(1, 1, "R2 positive above negative hi");
        feed(12'hFE8, 1);
        expect_state(1, 1, "R3 between negative limits holds");
        feed(12'hC90, 1);
        expect_state(0, 1, "R3 below negative lo clears");
        hi_limit = 12'h501; lo_limit = 12'h4B0;
        feed(12'h500, 1);
        expect_state(0, 1, "R2 one LSB under hi");
        feed(12'h501, 1);
        expect_state(1, 1, "R2 exact hi raises");

        // Interrupt mode, depth 2.
        hi_limit = 12'h500;
        pulse_gc;
        queue_sel = 2'b01;
        phase_tag = "R4";
        @(posedge clk); #1 intr_mode = 1'b1;
        idle(1);
        feed(12'h600, 2);
        expect_state(1, 1, "R4 interrupt raise on hi");
        feed(12'h4A0, 2);
        expect_state(1, 1, "R4 samples ignored while latched");
        pulse_read;
        expect_state(0, 1, "R4 read clears");
        phase_tag = "R5";
        feed(12'h600, 3);
        expect_state(0, 1, "R5 hi ignored after clear");
        feed(12'h4A0, 2);
        expect_state(1, 0, "R5 low-limit event");
        expect_state(1, 0, "R8 low-limit source");
        pulse_won;
        expect_state(0, 0, "R4 won response clears");
        feed(12'h4A0, 2);
        expect_state(0, 0, "R5 lo ignored after second clear");
        feed(12'h600, 2);
        expect_state(1, 1, "R5 back to high limit");
        pulse_sd;
        expect_state(0, 1, "R4 shutdown clears");

        phase_tag = "R7";
        feed(12'h4A0, 2);
        expect_state(1, 0, "R7 active low");
        #1 pol = 1'b1;
        #1 expect_state(1, 0, "R7 active high");
        idle(2);
        expect_state(1, 0, "R7 active high held");

        phase_tag = "R9";
        pulse_gc;
        expect_state(0, 0, "R9 general-call reset");
        feed(12'h600, 2);
        expect_state(1, 1, "R9 watches hi after reset");
        @(posedge clk); #1 intr_mode = 1'b0;
        idle(1);
        expect_state(0, 1, "R9 mode change clears");
        #1 pol = 1'b0;
        idle(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule